// File: doc/BRIEF.md
# Stream Identifier Span Filter

This block sits in front of a bank of event counters and decides, for every event presented to it, whether the event's stream identifier passes each counter slot's filter. Each slot holds a programmed match value and a span flag. With the span flag clear, the identifier must equal the value on every bit. With the span flag set, the value also encodes a don't-care field. The lowest zero bit of the value, together with all the one bits below it, marks the low bits that are ignored. The bits above that field must match the event identifier.

A single configuration port writes one slot per cycle. When a slot is written with its enable low, the slot is loaded with the all-pass setting instead: span set and a value of all ones. A mode input selects per-slot filtering or global filtering. In global mode, the filter of slot 0 decides for every slot. The per-slot match flags are registered. They appear one cycle after the event strobe and gate the increments of the counters that follow.

Top module: `sid_filter`

## Requirements
- R1: After reset every slot holds the all-pass setting (span set, value all ones), and `match_o` is all zeros until an event is presented.
- R2: With span clear, a slot flags a match only when the event identifier equals its programmed value on all bits.
- R3: With span set, the don't-care field runs from bit 0 up to and including the lowest zero bit of the value, and all bits above it must equal the identifier. For example, value 0x42 accepts exactly 0x42 and 0x43.
- R4: With span set and a value of all ones, every identifier matches.
- R5: A configuration write with `cfg_en_i` low loads the addressed slot with the all-pass setting, whatever the value and span inputs carry.
- R6: With `global_mode_i` high, every bit of `match_o` equals the result of slot 0's filter, and the filters of the other slots are ignored.
- R7: `match_o` is registered. It reflects the event presented in the previous cycle and is all zeros in the cycle after `evt_valid_i` was low.
- R8: An event presented in the same cycle as a configuration write is judged against the slot's old setting. The new setting applies from the next cycle.
- R9: A configuration write changes only the slot selected by `cfg_slot_i` (slot index is the binary value of `cfg_slot_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write one slot's filter setting |
| cfg_slot_i | input | SLOT_W | Slot written |
| cfg_val_i | input | SID_W | Match value to load |
| cfg_span_i | input | 1 | Span flag to load (1 = span match) |
| cfg_en_i | input | 1 | 1 loads value and span; 0 loads all-pass |
| global_mode_i | input | 1 | 1 = slot 0's filter decides for all slots |
| evt_valid_i | input | 1 | Event strobe |
| evt_sid_i | input | SID_W | Event stream identifier |
| match_o | output | NUM_SLOTS | Registered per-slot match flags |

## Verification
An event lookup and a configuration write to the same slot can fall in the same cycle. The bench raises both strobes together and expects the flags from the setting in force before the write. The very next event must then follow the new setting. Global mode adds a second overlap: the bench writes a slot other than 0 while global mode is active, and every flag must still track slot 0 alone.

// File: rtl/sid_filter_pkg.sv
package sid_filter_pkg;
  typedef enum logic {
    MODE_PER_SLOT = 1'b0,
    MODE_GLOBAL   = 1'b1
  } filt_mode_e;

  localparam logic ALL_PASS_SPAN = 1'b1;
endpackage

// File: rtl/sid_mask_dec.sv
module sid_mask_dec #(
  parameter int SID_W = 32
) (
  input  logic [SID_W-1:0] val_i,
  output logic [SID_W-1:0] mask_o
);
  // lowest zero bit and the ones below it; all ones wraps to a full mask
  logic [SID_W-1:0] val_inc;
  assign val_inc = val_i + SID_W'(1);
  assign mask_o  = val_i ^ val_inc;
endmodule

// File: rtl/sid_slot_match.sv
module sid_slot_match #(
  parameter int SID_W = 32
) (
  input  logic [SID_W-1:0] val_i,
  input  logic             span_i,
  input  logic [SID_W-1:0] sid_i,
  output logic             hit_o
);
  logic [SID_W-1:0] span_mask;
  logic [SID_W-1:0] care;
  logic [SID_W-1:0] diff;

  sid_mask_dec #(.SID_W(SID_W)) u_mask (
    .val_i (val_i),
    .mask_o(span_mask)
  );

  assign care  = span_i ? ~span_mask : '1;
  assign diff  = (sid_i ^ val_i) & care;
  assign hit_o = (diff == '0);
endmodule

// File: rtl/sid_filter.sv
module sid_filter
  import sid_filter_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SID_W     = 32,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [SLOT_W-1:0]    cfg_slot_i,
  input  logic [SID_W-1:0]     cfg_val_i,
  input  logic                 cfg_span_i,
  input  logic                 cfg_en_i,
  input  logic                 global_mode_i,
  input  logic                 evt_valid_i,
  input  logic [SID_W-1:0]     evt_sid_i,
  output logic [NUM_SLOTS-1:0] match_o
);
  logic [NUM_SLOTS-1:0][SID_W-1:0] flt_val;
  logic [NUM_SLOTS-1:0]            flt_span;
  logic [NUM_SLOTS-1:0]            slot_hit;
  logic [NUM_SLOTS-1:0]            sel_hit;
  filt_mode_e                      mode;

  assign mode = filt_mode_e'(global_mode_i);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic sel;
    assign sel = cfg_we_i && (cfg_slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flt_val[g]  <= '1;
        flt_span[g] <= ALL_PASS_SPAN;
      end else if (sel) begin
        flt_val[g]  <= cfg_en_i ? cfg_val_i  : '1;
        flt_span[g] <= cfg_en_i ? cfg_span_i : ALL_PASS_SPAN;
      end
    end

    sid_slot_match #(.SID_W(SID_W)) u_match (
      .val_i (flt_val[g]),
      .span_i(flt_span[g]),
      .sid_i (evt_sid_i),
      .hit_o (slot_hit[g])
    );
  end

  assign sel_hit = (mode == MODE_GLOBAL) ? {NUM_SLOTS{slot_hit[0]}} : slot_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_o <= '0;
    else         match_o <= evt_valid_i ? sel_hit : '0;
  end
endmodule

// File: rtl/sid_filter_chk.sv
module sid_filter_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int SID_W     = 32,
  parameter int SLOT_W    = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            cfg_we_i,
  input logic [SLOT_W-1:0]               cfg_slot_i,
  input logic                            cfg_en_i,
  input logic                            global_mode_i,
  input logic                            evt_valid_i,
  input logic [SID_W-1:0]                evt_sid_i,
  input logic [NUM_SLOTS-1:0]            match_o,
  input logic [NUM_SLOTS-1:0][SID_W-1:0] flt_val,
  input logic [NUM_SLOTS-1:0]            flt_span
);
  p_exact_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !cfg_we_i && !flt_span[0] && (evt_sid_i == flt_val[0]) |=> match_o[0]);

  p_exact_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !flt_span[0] && (evt_sid_i != flt_val[0]) |=> !match_o[0]);

  p_span_low_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && flt_span[0] && !flt_val[0][0] &&
    (evt_sid_i == (flt_val[0] | SID_W'(1))) |=> match_o[0]);

  p_full_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && flt_span[0] && (&flt_val[0]) |=> match_o[0]);

  p_allpass_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_en_i && (cfg_slot_i == '0) |=> (&flt_val[0]) && flt_span[0]);

  p_global_uniform_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && global_mode_i |=> (match_o == '0) || (match_o == {NUM_SLOTS{1'b1}}));

  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> match_o == '0);

  p_other_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_slot_i != '0) |=> $stable(flt_val[0]) && $stable(flt_span[0]));
endmodule

bind sid_filter sid_filter_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SID_W    (SID_W),
  .SLOT_W   (SLOT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_slot_i   (cfg_slot_i),
  .cfg_en_i     (cfg_en_i),
  .global_mode_i(global_mode_i),
  .evt_valid_i  (evt_valid_i),
  .evt_sid_i    (evt_sid_i),
  .match_o      (match_o),
  .flt_val      (flt_val),
  .flt_span     (flt_span)
);

// File: tb/sid_filter_tb.sv
`timescale 1ns/1ps
module sid_filter_tb;
  localparam int N = 4;
  localparam int W = 32;
  localparam int SW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [SW-1:0] cfg_slot_i = '0;
  logic [W-1:0]  cfg_val_i = '0;
  logic          cfg_span_i = 1'b0;
  logic          cfg_en_i = 1'b0;
  logic          global_mode_i = 1'b0;
  logic          evt_valid_i = 1'b0;
  logic [W-1:0]  evt_sid_i = '0;
  logic [N-1:0]  match_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] mv [N];
  logic         ms [N];

  always #2.5 clk_i = ~clk_i;

  sid_filter #(.NUM_SLOTS(N), .SID_W(W)) u_dut (.*);

  function automatic logic ref_hit(logic [W-1:0] v, logic s, logic [W-1:0] id);
    logic [W-1:0] m;
    bit done;
    if (!s) return id == v;
    m = '0;
    done = 0;
    for (int b = 0; b < W; b++) begin
      if (!done) begin
        m[b] = 1'b1;
        if (!v[b]) done = 1;
      end
    end
    return ((id ^ v) & ~m) == '0;
  endfunction

  function automatic logic [N-1:0] exp_vec(logic [W-1:0] id, logic glob);
    logic [N-1:0] e;
    for (int k = 0; k < N; k++)
      e[k] = glob ? ref_hit(mv[0], ms[0], id) : ref_hit(mv[k], ms[k], id);
    return e;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_wr(int slot, logic [W-1:0] v, logic s, logic en);
    mv[slot] = en ? v : '1;
    ms[slot] = en ? s : 1'b1;
  endtask

  task automatic cfg(int slot, logic [W-1:0] v, logic s, logic en);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_slot_i = SW'(slot); cfg_val_i = v; cfg_span_i = s; cfg_en_i = en;
    @(posedge clk_i); #1;
    cfg_we_i = 0;
    model_wr(slot, v, s, en);
  endtask

  task automatic ev(logic [W-1:0] id, logic glob, string tag);
    logic [N-1:0] e;
    @(negedge clk_i);
    evt_valid_i = 1; evt_sid_i = id; global_mode_i = glob;
    e = exp_vec(id, glob);
    @(posedge clk_i); #1;
    evt_valid_i = 0;
    check(tag, match_o, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) model_wr(k, '0, 1'b0, 1'b0);
    repeat (3) @(posedge clk_i);
    #1 check("R1 reset output", match_o, '0);
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1 check("R1 idle after reset", match_o, '0);
    // all-pass after reset
    ev(32'h0, 0, "R1 all-pass zero");
    ev(32'hFFFF_FFFF, 0, "R4 all-pass ones");
    for (int i = 0; i < 16; i++) ev($urandom, 0, "R4 all-pass random");

    // mixed slots, sweep identifiers
    cfg(0, 32'h42, 1, 1);
    cfg(1, 32'h42, 0, 1);
    cfg(2, 32'h10F, 1, 1);
    cfg(3, 32'h7, 1, 1);
    ev(32'h42, 0, "R3 0x42 accepted");
    ev(32'h43, 0, "R3 0x43 accepted");
    ev(32'h40, 0, "R3 0x40 rejected");
    for (int id = 0; id < 512; id++)
      ev(W'(id), 0, (id[0]) ? "R2 sweep exact" : "R3 sweep span");
    ev(32'h8000_0042, 0, "R2 high bit differs");

    // idle cycle
    @(negedge clk_i); evt_valid_i = 0;
    @(posedge clk_i); #1 check("R7 idle low", match_o, '0);

    // disable write loads all-pass
    cfg(1, 32'h5, 0, 0);
    for (int i = 0; i < 16; i++) ev($urandom, 0, "R5 disabled slot passes");
    ev(32'h42, 0, "R9 untouched slots");

    // global mode, including a write to slot 2 meanwhile
    for (int id = 0; id < 256; id++) ev(W'(id), 1, "R6 global sweep");
    cfg(2, 32'h0, 0, 1);
    for (int id = 60; id < 72; id++) ev(W'(id), 1, "R6 global ignores slot 2");

    // write and event together
    @(negedge clk_i);
    global_mode_i = 0;
    cfg_we_i = 1; cfg_slot_i = 0; cfg_val_i = 32'h100; cfg_span_i = 0; cfg_en_i = 1;
    evt_valid_i = 1; evt_sid_i = 32'h43;
    e = exp_vec(32'h43, 0);
    @(posedge clk_i); #1;
    cfg_we_i = 0; evt_valid_i = 0;
    check("R8 old setting same cycle", match_o, e);
    model_wr(0, 32'h100, 0, 1);
    ev(32'h43, 0, "R8 new setting miss");
    ev(32'h100, 0, "R8 new setting hit");

    // random values, identifiers near the value
    for (int i = 0; i < 200; i++) begin
      int k;
      logic s;
      k = $urandom_range(0, N - 1);
      v = $urandom;
      if (i % 3 == 0) v = v | ((W'(1) << $urandom_range(0, 12)) - 1);
      s = (i % 4 != 0);
      cfg(k, v, s, 1);
      for (int j = 0; j < 4; j++)
        ev(v ^ ($urandom & (32'hFFFF >> $urandom_range(0, 16))), 0,
           s ? "R3 random span" : "R2 random exact");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule